// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that lets an external bus master read and write a small bank of 8-bit registers. It answers to one fixed 7-bit device address. It keeps an internal register pointer, and it returns or stores one byte for each data phase. The raw SCL and SDA lines are sampled with a fast system clock through a two-flop synchronizer and a stability filter, which rejects short spikes. START and STOP are then decoded from the filtered lines.

Three transaction shapes are supported:

- A write: the address byte with R/W clear, then a pointer byte, then zero or more data bytes.
- A current-pointer read: the address byte with R/W set, followed by data bytes.
- A combined access: a write of the pointer, then a repeated START, then a read stream.

The pointer advances after every data byte, so a burst covers consecutive registers. The SDA output is an active-high "pull low" request for an external open-drain pad.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges only the address bytes 0x94 (write) and 0x95 (read), which are device address 7'b1001010 with R/W in bit 0. Any other address byte gets no acknowledge (SDA stays released on the 9th clock), and the bus is ignored until the next START.
- R2: In a write, the first byte after the address loads the pointer from its low log2(NUM_REGS) bits; the upper bits are ignored. Each following byte is stored in the register the pointer selects.
- R3: After each data byte is stored or sent, the pointer advances by one and wraps from NUM_REGS-1 to 0. Loading the pointer does not advance it.
- R4: A read that starts directly with 0x95 returns the register at the pointer left by the previous transaction.
- R5: After a pointer write, a repeated START and 0x95, the block streams bytes from consecutive registers while the master acknowledges (SDA low on the 9th clock). It stops driving once the master sends a not-acknowledge.
- R6: Bytes go MSB first. The block acknowledges an accepted address byte and every received byte by pulling SDA low during the 9th clock.
- R7: A pulse on SCL or SDA of 10 system clocks (50 ns at 200 MHz) or shorter has no effect, because the filter needs FILT_LEN = 12 stable samples.
- R8: The block changes its SDA drive only while SCL is low, and no earlier than DRIVE_DLY system clocks after SCL falls.
- R9: A START or STOP in the middle of a byte aborts the transfer. No partial byte is stored, and a repeated START restarts address matching at once.
- R10: After reset SDA is released, every register holds 0x00, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| sdaDriveLow | output | 1 | 1 requests the pad to pull SDA low |

## Verification
Every slave-driven level settles a fixed number of system clocks after the raw SCL falls. That number is the sum of two synchronizer stages, FILT_LEN filter samples, the edge register and DRIVE_DLY, about 24 clocks with the defaults. The bench master samples SDA in the middle of the SCL high phase, three quarter-bits (375 clocks) after the fall, so every acknowledge and data bit is read long after it is due and long before it may change. Stored values are never read from inside the design: each write is confirmed by a later read transaction, and the scoreboard pairs each received byte or acknowledge with the value the driver queued when it issued the transfer. A separate monitor times every change of the SDA drive against the raw SCL falling edge, which covers R8.

// File: rtl/i2cTgtPkg.sv
`timescale 1ns/1ps
package i2cTgtPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_ACK_TX
  } tgtState_t;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic shiftIn;   // sample SDA into the receive shifter
    logic loadPtr;   // received byte becomes the pointer
    logic writeReg;  // received byte is stored at the pointer
    logic incPtr;    // advance pointer with wrap
    logic loadTx;    // load transmit shifter from the bank
    logic shiftTx;   // move next transmit bit to the MSB
  } dpCtrl_t;

endpackage

// File: rtl/i2c_tgt_deglitch.sv
`timescale 1ns/1ps
module i2c_tgt_deglitch #(
  parameter int FILT_LEN = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      runCnt   <= '0;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        cleanOut <= syncQ[1];
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // the clean level only ever moves to a value the synchronizer already held
  assert_filter_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cleanOut != $past(cleanOut)) |-> ($past(syncQ[1]) == cleanOut));

endmodule

// File: rtl/i2c_tgt_control.sv
`timescale 1ns/1ps
module i2c_tgt_control
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'b1001010,
  parameter int         DRIVE_DLY = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpCtrl_t    st,
  output logic       sdaLow
);
  localparam int DW = $clog2(DRIVE_DLY + 1);

  tgtState_t     state;
  logic          sclQ, sdaQ;
  logic [3:0]    bitCnt;
  logic [DW-1:0] dlyCnt;
  logic          isRead, firstByte, masterAck;

  logic sclRise, sclFall, startDet, stopDet, tick, addrHit;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;
  assign tick     = (dlyCnt == DW'(1));
  assign addrHit  = (rxByte[7:1] == DEV_ADDR);

  // edge history and the post-fall drive delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      dlyCnt <= '0;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      if (sclFall)            dlyCnt <= DW'(DRIVE_DLY);
      else if (dlyCnt != '0)  dlyCnt <= dlyCnt - 1'b1;
    end
  end

  // datapath strobes
  always_comb begin
    st = '0;
    if (!startDet && !stopDet) begin
      case (state)
        ST_ADDR: st.shiftIn = sclRise;
        ST_RX: begin
          st.shiftIn = sclRise;
          if (tick && bitCnt == 4'd8) begin
            st.loadPtr  = firstByte;
            st.writeReg = ~firstByte;
            st.incPtr   = ~firstByte;
          end
        end
        ST_ACK_ADDR: st.loadTx = sclRise & isRead;
        ST_TX: begin
          st.shiftTx = sclRise;
          st.incPtr  = tick && (bitCnt == 4'd8);
        end
        ST_ACK_TX: st.loadTx = sclRise & ~sdaF;
        default: ;
      endcase
    end
  end

  // protocol sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      sdaLow    <= 1'b0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      sdaLow <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (tick && bitCnt == 4'd8) begin
            if (addrHit) begin
              state  <= ST_ACK_ADDR;
              sdaLow <= 1'b1;
              isRead <= rxByte[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK_ADDR: if (tick) begin
          bitCnt <= '0;
          if (isRead) begin
            state  <= ST_TX;
            sdaLow <= ~txMsb;
          end else begin
            state     <= ST_RX;
            sdaLow    <= 1'b0;
            firstByte <= 1'b1;
          end
        end
        ST_RX: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (tick && bitCnt == 4'd8) begin
            state  <= ST_ACK_RX;
            sdaLow <= 1'b1;
          end
        end
        ST_ACK_RX: if (tick) begin
          state     <= ST_RX;
          bitCnt    <= '0;
          sdaLow    <= 1'b0;
          firstByte <= 1'b0;
        end
        ST_TX: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (tick) begin
            if (bitCnt == 4'd8) begin
              state  <= ST_ACK_TX;
              sdaLow <= 1'b0;
            end else begin
              sdaLow <= ~txMsb;
            end
          end
        end
        ST_ACK_TX: begin
          if (sclRise) masterAck <= ~sdaF;
          if (tick) begin
            if (masterAck) begin
              state  <= ST_TX;
              bitCnt <= '0;
              sdaLow <= ~txMsb;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_drive_moves_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLow) |-> !sclF);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLow);

  assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.loadPtr, st.writeReg, st.loadTx}));

  assert_rx_commit_after_byte_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.writeReg || st.loadPtr) |=> (state == ST_ACK_RX) && sdaLow);

endmodule

// File: rtl/i2c_tgt_datapath.sv
`timescale 1ns/1ps
module i2c_tgt_datapath
  import i2cTgtPkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaF,
  input  dpCtrl_t    st,
  output logic [7:0] rxByte,
  output logic       txMsb
);
  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  logic [7:0]       regBank [NUM_REGS];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rxByte <= '0;
    else if (st.shiftIn) rxByte <= {rxByte[6:0], sdaF};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptr <= '0;
    else if (st.loadPtr)  ptr <= rxByte[PTR_W-1:0];
    else if (st.incPtr)   ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   regBank[i] <= '0;
      else if (st.writeReg && ptr == PTR_W'(i))    regBank[i] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txShift <= 8'hFF;
    else if (st.loadTx)   txShift <= regBank[ptr];
    else if (st.shiftTx)  txShift <= {txShift[6:0], 1'b1};
  end

  assign txMsb = txShift[7];

  assert_ptr_wraps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.incPtr && !st.loadPtr && ptr == LAST_IDX) |=> (ptr == '0));

endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'b1001010,
  parameter int         NUM_REGS  = 16,
  parameter int         FILT_LEN  = 12,
  parameter int         DRIVE_DLY = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines, cleanLines;
  dpCtrl_t    st;
  logic [7:0] rxByte;
  logic       txMsb;

  assign rawLines = {sdaIn, sclIn};

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    i2c_tgt_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawLines[i]),
      .cleanOut (cleanLines[i])
    );
  end

  i2c_tgt_control #(.DEV_ADDR(DEV_ADDR), .DRIVE_DLY(DRIVE_DLY)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclF   (cleanLines[0]),
    .sdaF   (cleanLines[1]),
    .rxByte (rxByte),
    .txMsb  (txMsb),
    .st     (st),
    .sdaLow (sdaDriveLow)
  );

  i2c_tgt_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .sdaF   (cleanLines[1]),
    .st     (st),
    .rxByte (rxByte),
    .txMsb  (txMsb)
  );

endmodule

// File: tb/i2c_reg_target_tb.sv
`timescale 1ns/1ps
module i2c_reg_target_tb;
  localparam int Q         = 125;   // quarter bit: 400 kHz SCL at 200 MHz
  localparam int DRIVE_DLY = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic sclM = 1'b1, sdaM = 1'b1, sclG = 1'b0, sdaG = 1'b0;
  logic sdaDriveLow, sdaBus, sclIn, sdaIn;
  assign sdaBus = sdaM & ~sdaDriveLow;
  assign sdaIn  = sdaBus & ~sdaG;
  assign sclIn  = sclM | sclG;

  i2c_reg_target #(.DRIVE_DLY(DRIVE_DLY)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaDriveLow(sdaDriveLow)
  );

  int nChecks = 0, nErrors = 0;
  int expQ[$];
  int actQ[$];
  string tagQ[$];

  task automatic waitN(int n); repeat (n) @(negedge clk); endtask

  task automatic checkNow(int act, int exp, string tag);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs observed items with queued expectations
  initial forever begin
    int a, e;
    string t;
    @(negedge clk);
    while (actQ.size() > 0 && expQ.size() > 0) begin
      a = actQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkNow(a, e, t);
    end
  end

  // R8 timing monitor against the raw master SCL
  int sinceFall = 0, r8Bad = 0, r8Moves = 0;
  logic prevDrive = 1'b0;
  always @(negedge clk) begin
    if (rstN && (sdaDriveLow !== prevDrive)) begin
      r8Moves++;
      if (sclM !== 1'b0 || sinceFall < DRIVE_DLY) r8Bad++;
    end
    prevDrive = sdaDriveLow;
    if (sclM) sinceFall = 0; else sinceFall++;
  end

  task automatic busStart(); sdaM = 1'b0; waitN(2*Q); sclM = 1'b0; endtask
  task automatic busRestart();
    waitN(Q); sdaM = 1'b1; waitN(Q); sclM = 1'b1; waitN(Q); sdaM = 1'b0; waitN(Q); sclM = 1'b0;
  endtask
  task automatic busStop();
    waitN(Q); sdaM = 1'b0; waitN(Q); sclM = 1'b1; waitN(Q); sdaM = 1'b1; waitN(2*Q);
  endtask

  // glitch: 1 = SCL spike while low, 2 = SDA dip while high
  task automatic sendBit(logic b, int glitch);
    if (glitch == 1) begin sclG = 1'b1; waitN(10); sclG = 1'b0; waitN(Q-10); end
    else waitN(Q);
    sdaM = b; waitN(Q); sclM = 1'b1;
    if (glitch == 2) begin waitN(Q/2); sdaG = 1'b1; waitN(10); sdaG = 1'b0; waitN(2*Q-Q/2-10); end
    else waitN(2*Q);
    sclM = 1'b0;
  endtask

  task automatic recvBit(output logic b);
    waitN(Q); sdaM = 1'b1; waitN(Q); sclM = 1'b1; waitN(Q); b = sdaBus; waitN(Q); sclM = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] v, int expAck, string tag, int gBit = -1, int gMode = 0);
    logic ack;
    for (int i = 7; i >= 0; i--) sendBit(v[i], (i == gBit) ? gMode : 0);
    recvBit(ack);
    expQ.push_back(expAck); tagQ.push_back(tag); actQ.push_back(int'(ack));
  endtask

  task automatic recvByte(logic [7:0] expVal, logic nack, string tag);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    expQ.push_back(int'(expVal)); tagQ.push_back(tag); actQ.push_back(int'(v));
    sendBit(nack, 0);
  endtask

  task automatic finishRun();
    waitN(5);
    checkNow((r8Bad == 0 && r8Moves > 0) ? 1 : 0, 1, "R8 drive changes only in SCL low after delay");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    waitN(5);
    checkNow(int'(sdaDriveLow), 0, "R10 SDA released in reset");
    rstN = 1'b1;
    waitN(20);
    checkNow(int'(sdaDriveLow), 0, "R10 SDA released after reset");

    // R2/R6: write pointer 3, then two data bytes (regs 3,4), pointer ends at 5
    busStart();
    sendByte(8'h94, 0, "R1 write address acknowledged");
    sendByte(8'h03, 0, "R2 pointer byte acknowledged");
    sendByte(8'hA5, 0, "R6 data byte acknowledged");
    sendByte(8'h3C, 0, "R6 second data byte acknowledged");
    busStop();

    // R5: combined read of regs 3,4
    busStart();
    sendByte(8'h94, 0, "R5 write address acknowledged");
    sendByte(8'h03, 0, "R5 pointer byte acknowledged");
    busRestart();
    sendByte(8'h95, 0, "R1 read address acknowledged");
    recvByte(8'hA5, 1'b0, "R5 first streamed byte reg3");
    recvByte(8'h3C, 1'b1, "R3 R5 second streamed byte reg4");
    busStop();

    // R2/R3: pointer 0xFF selects reg15, burst wraps to regs 0 and 1
    busStart();
    sendByte(8'h94, 0, "R2 write address acknowledged");
    sendByte(8'hFF, 0, "R2 wide pointer acknowledged");
    sendByte(8'h11, 0, "R3 write reg15");
    sendByte(8'h22, 0, "R3 write reg0 after wrap");
    sendByte(8'h33, 0, "R3 write reg1");
    busStop();

    // R1: foreign address is not acknowledged
    busStart();
    sendByte(8'h96, 1, "R1 foreign address not acknowledged");
    busStop();

    // R3/R5: combined read across the wrap, pointer ends at 1
    busStart();
    sendByte(8'h94, 0, "R5 write address acknowledged");
    sendByte(8'h0F, 0, "R5 pointer 15 acknowledged");
    busRestart();
    sendByte(8'h95, 0, "R5 read address acknowledged");
    recvByte(8'h11, 1'b0, "R3 read reg15");
    recvByte(8'h22, 1'b1, "R3 read reg0 after wrap");
    busStop();

    // R4: current-pointer read returns reg1
    busStart();
    sendByte(8'h95, 0, "R4 read address acknowledged");
    recvByte(8'h33, 1'b1, "R4 current pointer read reg1");
    busStop();

    // R9: partial byte cut by repeated START, then by STOP
    busStart();
    sendByte(8'h94, 0, "R9 write address acknowledged");
    sendByte(8'h08, 0, "R9 pointer 8 acknowledged");
    for (int i = 0; i < 4; i++) sendBit(1'b1, 0);
    busRestart();
    sendByte(8'h94, 0, "R9 address after restart acknowledged");
    sendByte(8'h09, 0, "R9 pointer 9 acknowledged");
    for (int i = 0; i < 4; i++) sendBit(1'b0, 0);
    busStop();

    // R7: write 0x5A to reg10 with a spike on SCL and a dip on SDA
    busStart();
    sendByte(8'h94, 0, "R7 write address acknowledged");
    sendByte(8'h0A, 0, "R7 pointer 10 acknowledged");
    sendByte(8'h5A, 0, "R7 glitched byte acknowledged", 7, 1);
    busStop();
    busStart();
    sendByte(8'h94, 0, "R7 write address acknowledged");
    sendByte(8'h0A, 0, "R7 pointer 10 acknowledged");
    sendByte(8'hC3, 0, "R7 dip on SDA high bit acknowledged", 6, 2);
    busStop();

    // R9/R10: regs 8,9 untouched and zero; reg10 holds last glitched write
    busStart();
    sendByte(8'h94, 0, "R9 write address acknowledged");
    sendByte(8'h08, 0, "R9 pointer 8 acknowledged");
    busRestart();
    sendByte(8'h95, 0, "R9 read address acknowledged");
    recvByte(8'h00, 1'b0, "R9 R10 reg8 not written by partial byte");
    recvByte(8'h00, 1'b0, "R9 R10 reg9 not written by partial byte");
    recvByte(8'hC3, 1'b1, "R7 reg10 holds unglitched value");
    busStop();

    finishRun();
  end
endmodule